// File: doc/BRIEF.md
# Rotating 8-PSK Symbol Mapper and Derotator

This block is the transmit front end of a modulator whose constellation turns on every symbol. Serial bits arrive with a valid qualifier. Each run of three accepted bits becomes one symbol. The symbol is Gray-mapped onto one of eight phases. A rotation is then added that grows by 3π/8 from one symbol to the next. The phase is held as a 4-bit index in units of π/8, so successive transmitted points land on a sixteen-point circle.

For every symbol the block produces a one-cycle strobe, the 4-bit phase index, and signed I and Q words taken from a cosine/sine table. These feed a pulse shaper that runs at eight samples per symbol; at the nominal rates, 750 kbit/s of input becomes 250 ksymbol/s.

The receive side has its own accumulator. Each received 4-bit phase index has the rotation taken off, stepping −3π/8 per sample, so the result returns to the 8-PSK grid before decision. A shared sync input zeroes both accumulators, which keeps the two ends aligned.

Top module: `psk8_rot_mapper`

## Requirements
- R1: After reset, `sym_stb` and `rx_stb` are low, and `phase_idx`, `i_out`, `q_out` and `rx_dphase` are zero.
- R2: Every third accepted bit completes a symbol, and the first bit of the three is the symbol's MSB. `sym_stb` is high for exactly the one cycle after the clock edge that accepted the third bit, and at no other time.
- R3: The 3-bit symbol s is mapped to an 8-PSK index p such that s = p XOR (p >> 1). The transmitted index is phase_idx = (2·p + acc) mod 16.
- R4: The transmit accumulator acc starts at 0 and adds 3 (mod 16) after each emitted symbol.
- R5: A cycle with `bit_vld` low changes neither the partial symbol nor the accumulator, whatever `bit_in` holds.
- R6: A cycle with `sync` high zeroes both accumulators and drops any partial symbol. A bit or received sample presented in the same cycle is discarded and produces no strobe.
- R7: With the symbol, `i_out` = round(AMP·cos(k·π/8)) and `q_out` = round(AMP·sin(k·π/8)), where k = `phase_idx` and AMP = 127 by default.
- R8: For each `rx_vld` cycle without `sync`, `rx_stb` rises on the next cycle and `rx_dphase` = (`rx_phase` − racc) mod 16. The receive accumulator racc starts at 0 and then adds 3 (mod 16).
- R9: Both accumulators wrap modulo 16 without disturbing the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Zeroes both rotation accumulators and the bit counter |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies bit_in |
| sym_stb | output | 1 | One-cycle strobe marking a new symbol |
| phase_idx | output | 4 | Rotated phase index, units of π/8 |
| i_out | output | W | Signed in-phase value |
| q_out | output | W | Signed quadrature value |
| rx_phase | input | 4 | Received phase index, units of π/8 |
| rx_vld | input | 1 | Qualifies rx_phase |
| rx_stb | output | 1 | Strobe marking a derotated result |
| rx_dphase | output | 4 | Derotated phase index |

## Verification
A wrong transmit accumulator shows up on the very next symbol as an offset phase index. The same offset then appears in the I/Q pair, and it stays wrong for every later symbol until sync, so a single compare exposes it. A slipped bit counter is visible within one symbol: the strobe comes too early or too late, or the symbol bits are misaligned. A receive accumulator fault corrupts the first derotated sample after it occurs. The scoreboard therefore compares every symbol, across sync events, gapped input and more than one full turn of the accumulators.

// File: rtl/psk8_rot_mapper.sv
`timescale 1ns/1ps
module psk8_rot_mapper #(
  parameter int W    = 8,
  parameter int AMP  = 127,
  parameter int STEP = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync,
  input  logic                bit_in,
  input  logic                bit_vld,
  output logic                sym_stb,
  output logic [3:0]          phase_idx,
  output logic signed [W-1:0] i_out,
  output logic signed [W-1:0] q_out,
  input  logic [3:0]          rx_phase,
  input  logic                rx_vld,
  output logic                rx_stb,
  output logic [3:0]          rx_dphase
);
  localparam longint C1 = (longint'(AMP) * 92388 + 50000) / 100000;
  localparam longint C2 = (longint'(AMP) * 70711 + 50000) / 100000;
  localparam longint C3 = (longint'(AMP) * 38268 + 50000) / 100000;
  localparam logic [3:0] STEP4 = STEP[3:0];

  function automatic logic signed [W-1:0] cos_lut(input logic [3:0] k);
    logic [3:0] j;
    logic neg;
    logic signed [W-1:0] m;
    if (k <= 4'd4)       begin j = k;                neg = 1'b0; end
    else if (k <= 4'd8)  begin j = 4'd8 - k;         neg = 1'b1; end
    else if (k <= 4'd12) begin j = k - 4'd8;         neg = 1'b1; end
    else                 begin j = 4'd0 - k;         neg = 1'b0; end
    case (j)
      4'd0:    m = W'(AMP);
      4'd1:    m = W'(C1);
      4'd2:    m = W'(C2);
      4'd3:    m = W'(C3);
      default: m = '0;
    endcase
    return neg ? -m : m;
  endfunction

  logic [1:0] cnt, shf;
  logic [3:0] tx_acc, rx_acc;

  wire [2:0] sym  = {shf, bit_in};
  wire [2:0] p8   = {sym[2], sym[2] ^ sym[1], ^sym};
  wire       last = bit_vld && !sync && cnt == 2'd2;
  wire [3:0] nxt  = {p8, 1'b0} + tx_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; shf <= '0; tx_acc <= '0; rx_acc <= '0;
      sym_stb <= 1'b0; phase_idx <= '0; i_out <= '0; q_out <= '0;
      rx_stb <= 1'b0; rx_dphase <= '0;
    end else begin
      sym_stb <= 1'b0;
      rx_stb  <= 1'b0;
      if (sync) begin
        cnt <= '0; tx_acc <= '0; rx_acc <= '0;
      end else begin
        if (bit_vld) begin
          shf <= {shf[0], bit_in};
          cnt <= last ? 2'd0 : cnt + 2'd1;
        end
        if (last) begin
          phase_idx <= nxt;
          i_out     <= cos_lut(nxt);
          q_out     <= cos_lut(nxt + 4'd12);
          tx_acc    <= tx_acc + STEP4;
          sym_stb   <= 1'b1;
        end
        if (rx_vld) begin
          rx_dphase <= rx_phase - rx_acc;
          rx_acc    <= rx_acc + STEP4;
          rx_stb    <= 1'b1;
        end
      end
    end
  end

  // R2
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> !sym_stb);
  // R4
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !$past(sync)) |-> (tx_acc == 4'($past(tx_acc) + STEP4)));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !sync) |=> ($stable(cnt) && $stable(tx_acc) && !sym_stb));
  // R6
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (tx_acc == 4'd0 && rx_acc == 4'd0 && cnt == 2'd0 && !sym_stb && !rx_stb));
  // R8
  rx_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !sync) |=> rx_stb);
  // R8
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> !rx_stb);
endmodule

// File: tb/psk8_rot_mapper_tb_top.sv
`timescale 1ns/1ps
module psk8_rot_mapper_tb_top;
  localparam int W = 8, AMP = 127;
  logic clk = 0, rst_n = 0, sync = 0, bit_in = 0, bit_vld = 0, rx_vld = 0;
  logic [3:0] rx_phase = 0;
  logic sym_stb, rx_stb;
  logic [3:0] phase_idx, rx_dphase;
  logic signed [W-1:0] i_out, q_out;

  psk8_rot_mapper #(.W(W), .AMP(AMP), .STEP(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .bit_in(bit_in), .bit_vld(bit_vld),
    .sym_stb(sym_stb), .phase_idx(phase_idx), .i_out(i_out), .q_out(q_out),
    .rx_phase(rx_phase), .rx_vld(rx_vld), .rx_stb(rx_stb), .rx_dphase(rx_dphase));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int q_ph[$], q_rx[$];
  int mcnt = 0, macc = 0, racc = 0, mbits = 0;

  function automatic int ref_trig(int k, bit is_sin);
    real v = AMP * (is_sin ? $sin(k * 3.14159265358979 / 8.0) : $cos(k * 3.14159265358979 / 8.0));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one call per cycle, pushes expected results into the scoreboard
  task automatic drive(bit b, bit v, bit s, int rph, bit rv);
    @(negedge clk);
    bit_in = b; bit_vld = v; sync = s; rx_phase = 4'(rph); rx_vld = rv;
    if (s) begin
      mcnt = 0; macc = 0; racc = 0;
    end else begin
      if (v) begin
        mbits = ((mbits << 1) | int'(b)) & 7;
        if (mcnt == 2) begin
          int p;
          p = mbits;
          p = p ^ (p >> 1); p = p ^ (p >> 2);
          q_ph.push_back((2 * p + macc) % 16);
          macc = (macc + 3) % 16;
          mcnt = 0;
        end else mcnt++;
      end
      if (rv) begin
        q_rx.push_back((rph - racc + 16) % 16);
        racc = (racc + 3) % 16;
      end
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (sym_stb) begin
      if (q_ph.size() == 0) check(0, "R2 unexpected symbol strobe", 1, 0);
      else begin
        int e;
        e = q_ph.pop_front();
        check(phase_idx == 4'(e), "R3 R4 phase index", int'(phase_idx), e);
        check(int'(i_out) == ref_trig(e, 0), "R7 I value", int'(i_out), ref_trig(e, 0));
        check(int'(q_out) == ref_trig(e, 1), "R7 Q value", int'(q_out), ref_trig(e, 1));
      end
    end
    if (rx_stb) begin
      if (q_rx.size() == 0) check(0, "R8 unexpected rx strobe", 1, 0);
      else begin
        int e;
        e = q_rx.pop_front();
        check(rx_dphase == 4'(e), "R8 R9 derotated phase", int'(rx_dphase), e);
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sym_stb == 0, "R1 sym_stb", int'(sym_stb), 0);
    check(rx_stb == 0, "R1 rx_stb", int'(rx_stb), 0);
    check(phase_idx == 0, "R1 phase_idx", int'(phase_idx), 0);
    check(i_out == 0 && q_out == 0, "R1 iq", int'(i_out), 0);
    check(rx_dphase == 0, "R1 rx_dphase", int'(rx_dphase), 0);
    rst_n = 1;
    // R2 R3 all eight symbols back to back, MSB first
    for (int s = 0; s < 8; s++)
      for (int k = 2; k >= 0; k--) drive(s[k], 1, 0, 0, 0);
    // R5 gaps with garbage on bit_in
    for (int s = 7; s >= 0; s--)
      for (int k = 2; k >= 0; k--) begin
        drive(~s[k], 0, 0, 0, 0);
        drive(s[k], 1, 0, 0, 0);
        drive(s[k], 0, 0, 0, 0);
      end
    // R6 sync mid-symbol, then a bit offered with sync is dropped
    drive(1, 1, 0, 0, 0); drive(0, 1, 0, 0, 0);
    drive(1, 1, 1, 0, 0);
    for (int n = 0; n < 30; n++) drive(n[0] ^ n[2], 1, 0, 0, 0);
    // R8 R9 receive path, gaps, sync with a dropped sample
    for (int n = 0; n < 20; n++) drive(0, 0, 0, (n * 5) % 16, n % 3 != 2);
    drive(0, 0, 1, 9, 1);
    for (int n = 0; n < 12; n++) drive(0, 0, 0, (n * 7 + 1) % 16, 1);
    // simultaneous traffic on both paths
    for (int n = 0; n < 24; n++) drive(n[1], 1, 0, n % 16, 1);
    drive(0, 0, 0, 0, 0);
    repeat (3) drive(0, 0, 0, 0, 0);
    check(q_ph.size() == 0, "R2 missing symbol strobes", q_ph.size(), 0);
    check(q_rx.size() == 0, "R8 missing rx strobes", q_rx.size(), 0);
    finish_run();
  end
endmodule